// File: doc/BRIEF.md
# Selectable-Resolution Tracking Angle Counter

This block is the digital half of a type II tracking shaft-angle converter. An external rate oscillator supplies one-cycle step pulses and a direction level, and an error processor raises an in-band flag while the loop error sits inside its hysteresis band. Each accepted step moves a modulo-one-turn angle counter by one LSB of the selected resolution. The angle word is natural binary with its MSB weighted 180 degrees. Four resolutions are selectable, and bits finer than the selected LSB always read as zero.

For readers, an active-low inhibit freezes the presented word while the counter keeps tracking underneath. Releasing the inhibit fires a busy pulse so the reader knows fresh data is present. An active-low enable asserts the bus drive enable. An active-low load turns the angle lines into a preset path. For turns counting, the block gives a busy pulse on every LSB change, a direction flag, and an active-low ripple pulse each time the count wraps through zero.

Top module: `angle_track_counter`

## Requirements
- R1: After reset, angle_o is 0, busy_o is 0, ripple_no is 1 and dir_o is 1.
- R2: res_sel_i picks the resolution and its LSB weight on the 16-bit word: 2'b00 = 10 bits (LSB 0x0040), 2'b01 = 12 bits (0x0010), 2'b10 = 14 bits (0x0004), 2'b11 = 16 bits (0x0001). Bit 15 is weighted 180 degrees.
- R3: Bits of angle_o below the selected LSB read 0 in every mode.
- R4: A step_i pulse accepted at a clock edge adds one LSB when dir_up_i is 1 and subtracts one LSB when it is 0. The count wraps modulo one turn, and dir_o takes dir_up_i from that step.
- R5: A step is ignored while in_band_i is 1, and the angle does not change.
- R6: busy_o goes high in the cycle after the edge that accepts a step and stays high for 4 cycles. Each new step restarts the 4 cycles.
- R7: When an accepted step wraps the count through zero in either direction, ripple_no is low for 2 cycles, starting one cycle after busy_o rises.
- R8: While inhibit_ni is 0, angle_o is frozen but steps still update the count. When inhibit_ni returns to 1, busy_o is high in the next cycle and angle_o shows the current count.
- R9: angle_oe_o is 1 only when enable_ni is 0 and load_ni is 1.
- R10: While load_ni is 0, the count follows angle_i and steps are ignored. The value present at the last edge with load_ni low is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| res_sel_i | input | 2 | Resolution select |
| step_i | input | 1 | One-cycle step pulse from rate oscillator |
| dir_up_i | input | 1 | Step direction, 1 = up (clockwise) |
| in_band_i | input | 1 | Loop error inside hysteresis band |
| inhibit_ni | input | 1 | Active-low output freeze |
| enable_ni | input | 1 | Active-low output bus enable |
| load_ni | input | 1 | Active-low preset load |
| angle_i | input | 16 | Preset angle value |
| angle_o | output | 16 | Angle word |
| angle_oe_o | output | 1 | Bus drive enable for angle_o |
| busy_o | output | 1 | Pulse on each LSB change or inhibit release |
| dir_o | output | 1 | Last counting direction, 1 = up |
| ripple_no | output | 1 | Active-low zero-crossing pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 4-cycle busy pulse and a 2-cycle ripple pulse. With these values the full wrap at 0xFFFF/0x0000 and every resolution code can be reached within a few steps. Walking the step table through changing resolution codes leaves low count bits set, which exposes the zero-fill masking when the mode is coarsened. Directed sequences then measure the busy and ripple windows cycle by cycle, and cover inhibit freezing and release, the in-band guard and the preset path.

// File: rtl/angle_trk_pkg.sv
package angle_trk_pkg;
  localparam int unsigned RES_CODES = 4;
  localparam int unsigned RES_STEP  = 2;

  typedef enum logic [1:0] {
    RES_10 = 2'b00,
    RES_12 = 2'b01,
    RES_14 = 2'b10,
    RES_16 = 2'b11
  } res_sel_e;

  // number of zero-filled low bits for a resolution code
  function automatic int unsigned res_shift(logic [1:0] sel);
    return (RES_CODES - 1 - int'(sel)) * RES_STEP;
  endfunction
endpackage

// File: rtl/angle_pulse_timer.sv
module angle_pulse_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= CW'(LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/angle_step_unit.sv
module angle_step_unit #(
  parameter int unsigned ANG_W   = 16,
  parameter int unsigned SHIFT_W = $clog2(ANG_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_ok_i,
  input  logic               up_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               load_i,
  input  logic [ANG_W-1:0]   preset_i,
  output logic [ANG_W-1:0]   cnt_d_o,
  output logic [ANG_W-1:0]   cnt_q_o,
  output logic               wrap_o
);
  logic [ANG_W-1:0] cnt_q, lsb, low_mask;

  assign lsb      = {{(ANG_W-1){1'b0}}, 1'b1} << shift_i;
  assign low_mask = lsb - 1'b1;

  always_comb begin
    cnt_d_o = cnt_q;
    wrap_o  = 1'b0;
    if (load_i) begin
      cnt_d_o = preset_i;
    end else if (step_ok_i) begin
      if (up_i) begin
        cnt_d_o = cnt_q + lsb;
        wrap_o  = &(cnt_q | low_mask);
      end else begin
        cnt_d_o = cnt_q - lsb;
        wrap_o  = ((cnt_q & ~low_mask) == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d_o;
  end

  assign cnt_q_o = cnt_q;
endmodule

// File: rtl/angle_track_counter.sv
module angle_track_counter #(
  parameter int unsigned ANG_W    = 16,
  parameter int unsigned BUSY_LEN = 4,
  parameter int unsigned RIP_LEN  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       res_sel_i,
  input  logic             step_i,
  input  logic             dir_up_i,
  input  logic             in_band_i,
  input  logic             inhibit_ni,
  input  logic             enable_ni,
  input  logic             load_ni,
  input  logic [ANG_W-1:0] angle_i,
  output logic [ANG_W-1:0] angle_o,
  output logic             angle_oe_o,
  output logic             busy_o,
  output logic             dir_o,
  output logic             ripple_no
);
  import angle_trk_pkg::*;
  localparam int unsigned SHIFT_W = $clog2(ANG_W);

  logic [SHIFT_W-1:0] shift;
  logic [ANG_W-1:0]   cnt_d, cnt_q, held_q, out_mask;
  logic step_ok, wrap, inh_q, release_ev, rip_arm_q, rip_act;

  assign shift    = SHIFT_W'(res_shift(res_sel_i));
  assign out_mask = ~(({{(ANG_W-1){1'b0}}, 1'b1} << shift) - 1'b1);
  assign step_ok  = step_i & ~in_band_i & load_ni;

  angle_step_unit #(.ANG_W(ANG_W), .SHIFT_W(SHIFT_W)) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_ok_i (step_ok),
    .up_i      (dir_up_i),
    .shift_i   (shift),
    .load_i    (~load_ni),
    .preset_i  (angle_i),
    .cnt_d_o   (cnt_d),
    .cnt_q_o   (cnt_q),
    .wrap_o    (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q    <= '0;
      inh_q     <= 1'b1;
      dir_o     <= 1'b1;
      rip_arm_q <= 1'b0;
    end else begin
      if (inhibit_ni) held_q <= cnt_d;
      inh_q     <= inhibit_ni;
      rip_arm_q <= wrap;
      if (step_ok) dir_o <= dir_up_i;
    end
  end

  assign release_ev = inhibit_ni & ~inh_q;

  angle_pulse_timer #(.LEN(BUSY_LEN)) u_busy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (step_ok | release_ev),
    .active_o (busy_o)
  );

  // ripple trails busy by one cycle
  angle_pulse_timer #(.LEN(RIP_LEN)) u_ripple (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (rip_arm_q),
    .active_o (rip_act)
  );

  assign ripple_no  = ~rip_act;
  assign angle_o    = (inhibit_ni ? cnt_q : held_q) & out_mask;
  assign angle_oe_o = ~enable_ni & load_ni;
endmodule

// File: rtl/angle_track_counter_chk.sv
module angle_track_counter_chk #(
  parameter int unsigned ANG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       res_sel_i,
  input logic             step_i,
  input logic             dir_up_i,
  input logic             in_band_i,
  input logic             inhibit_ni,
  input logic             enable_ni,
  input logic             load_ni,
  input logic [ANG_W-1:0] angle_i,
  input logic [ANG_W-1:0] angle_o,
  input logic             angle_oe_o,
  input logic             busy_o,
  input logic             dir_o,
  input logic             ripple_no
);
  a_r3_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_sel_i == 2'b00) |-> (angle_o[5:0] == 6'd0));

  a_r4_dir_follows_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !in_band_i && load_ni) |=> (dir_o == $past(dir_up_i)));

  a_r5_in_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_band_i && load_ni && inhibit_ni) |=>
      (!inhibit_ni || res_sel_i != $past(res_sel_i) || angle_o == $past(angle_o)));

  a_r6_busy_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !in_band_i && load_ni) |=> busy_o);

  a_r7_ripple_inside_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ripple_no |-> busy_o);

  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inhibit_ni && $past(!inhibit_ni) && $stable(res_sel_i)) |-> $stable(angle_o));

  a_r8_release_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(inhibit_ni) && $past(rst_ni)) |=> busy_o);

  a_r9_no_drive_in_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |-> !angle_oe_o);
endmodule

bind angle_track_counter angle_track_counter_chk #(.ANG_W(ANG_W)) u_chk (.*);

// File: tb/angle_track_counter_bench.sv
module angle_track_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  res_sel = 2'b11;
  logic        step = 1'b0, dir_up = 1'b1, in_band = 1'b0;
  logic        inhibit_n = 1'b1, enable_n = 1'b0, load_n = 1'b1;
  logic [15:0] angle_in = '0;
  logic [15:0] angle;
  logic        oe, busy, dir, ripple_n;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  angle_track_counter u_angle_track_counter (
    .clk_i(clk), .rst_ni(rst_n), .res_sel_i(res_sel), .step_i(step),
    .dir_up_i(dir_up), .in_band_i(in_band), .inhibit_ni(inhibit_n),
    .enable_ni(enable_n), .load_ni(load_n), .angle_i(angle_in),
    .angle_o(angle), .angle_oe_o(oe), .busy_o(busy), .dir_o(dir),
    .ripple_no(ripple_n)
  );

  // {sel[1:0], dir, steps[3:0], expected angle[15:0]}
  localparam logic [22:0] VEC [7] = '{
    {2'b11, 1'b1, 4'd5, 16'h0005},   // R2 16-bit up
    {2'b11, 1'b0, 4'd7, 16'hFFFE},   // R4 down through zero
    {2'b10, 1'b1, 4'd1, 16'h0000},   // R3 14-bit, raw 0x0002
    {2'b10, 1'b1, 4'd3, 16'h000C},   // R2 14-bit LSB 4
    {2'b00, 1'b0, 4'd1, 16'hFFC0},   // R2 10-bit LSB 0x40
    {2'b01, 1'b1, 4'd4, 16'h0000},   // R3 12-bit, raw 0x000E
    {2'b01, 1'b1, 4'd2, 16'h0020}    // R2 12-bit LSB 0x10
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic steps(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dir_up = up; step = 1'b1;
      @(negedge clk); step = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic preset(input logic [15:0] v);
    @(negedge clk); load_n = 1'b0; angle_in = v; step = 1'b1;
    @(negedge clk); load_n = 1'b1; step = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 angle", angle, 16'h0000);
    chk("R1 busy", 16'(busy), 16'h0000);
    chk("R1 ripple", 16'(ripple_n), 16'h0001);
    chk("R1 dir", 16'(dir), 16'h0001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 table walk
    foreach (VEC[k]) begin
      res_sel = VEC[k][22:21];
      steps(VEC[k][20], int'(VEC[k][19:16]));
      chk($sformatf("R2 R3 R4 vec%0d", k), angle, VEC[k][15:0]);
    end
    settle();

    // R9 R10 preset with step ignored during load
    res_sel = 2'b11;
    chk("R9 oe enabled", 16'(oe), 16'h0001);
    @(negedge clk); load_n = 1'b0; angle_in = 16'h1234; step = 1'b1;
    #1 chk("R9 oe in load", 16'(oe), 16'h0000);
    @(negedge clk); load_n = 1'b1; step = 1'b0; angle_in = 16'h0;
    chk("R10 preset", angle, 16'h1234);
    enable_n = 1'b1;
    #1 chk("R9 oe disabled", 16'(oe), 16'h0000);
    enable_n = 1'b0;
    res_sel = 2'b00;
    #1 chk("R3 10-bit zero fill", angle, 16'h1200);
    res_sel = 2'b11;
    settle();

    // R6 busy width
    preset(16'h0000);
    settle();
    steps(1'b1, 1);
    highs = 0;
    for (int i = 0; i < 6; i++) begin
      if (busy) highs++;
      @(negedge clk);
    end
    chk("R6 busy cycles", 16'(highs), 16'd4);
    chk("R4 up one", angle, 16'h0001);

    // R7 ripple on down wrap
    preset(16'h0000);
    settle();
    steps(1'b0, 1);
    chk("R7 ripple idle first", 16'(ripple_n), 16'h0001);
    @(negedge clk); chk("R7 ripple low 1", 16'(ripple_n), 16'h0000);
    @(negedge clk); chk("R7 ripple low 2", 16'(ripple_n), 16'h0000);
    @(negedge clk); chk("R7 ripple ends", 16'(ripple_n), 16'h0001);
    chk("R4 wrap down", angle, 16'hFFFF);
    chk("R4 dir down", 16'(dir), 16'h0000);
    settle();
    // R7 ripple on up wrap
    steps(1'b1, 1);
    @(negedge clk); chk("R7 up wrap ripple", 16'(ripple_n), 16'h0000);
    chk("R4 wrap up", angle, 16'h0000);
    settle();
    // R7 no ripple without crossing
    steps(1'b1, 1);
    highs = 0;
    for (int i = 0; i < 5; i++) begin
      if (!ripple_n) highs++;
      @(negedge clk);
    end
    chk("R7 no ripple", 16'(highs), 16'd0);

    // R5 in-band ignores steps
    settle();
    in_band = 1'b1;
    steps(1'b1, 2);
    chk("R5 angle held", angle, 16'h0001);
    chk("R5 no busy", 16'(busy), 16'h0000);
    in_band = 1'b0;

    // R8 inhibit freeze and release
    @(negedge clk); inhibit_n = 1'b0;
    steps(1'b1, 3);
    chk("R8 frozen", angle, 16'h0001);
    settle();
    chk("R8 frozen after", angle, 16'h0001);
    inhibit_n = 1'b1;
    @(negedge clk);
    chk("R8 release busy", 16'(busy), 16'h0001);
    chk("R8 release angle", angle, 16'h0004);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule